// File: doc/BRIEF.md
# UART interrupt status aggregator

This block collects the interrupt causes of a FIFO-based UART into one 32-bit status word and drives a single interrupt line. There are five causes: receiver line error, received data available, character timeout, transmit space available and modem status change. Each cause becomes pending only while its enable in a four-bit configuration input is set. Several causes can be pending at the same time. The host reads the word once, services every cause it finds, and then writes the serviced cause mask to the low byte of the word. That write clears only the named causes.

The status word also carries the modem status byte (delta flags and current levels), the line status byte passed through from the receiver, and the 10-bit receive fill count. The count is split between the top byte and bits [7:6]. Writes to the low byte never disturb bits [7:6]. The serial shifters, the baud generator and the FIFO storage sit outside this block. They supply the event pulses and levels it needs.

Top module: `uart_irq_status`

## Requirements
- R1: After synchronous reset, the cause bits [4:0], the modem delta bits [11:8], the modem level bits [15:12] and `irq` are all 0.
- R2: `status_word` places rx_count[7:0] at [31:24] and rx_count[9:8] at [7:6]. Bit 5 reads 0. `lsr_in` appears unchanged at [23:16], with no delay.
- R3: The line-status cause (bit 0) is set at the clock edge after `lsr_in` has any of its bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) or 7 (FIFO error) high while cfg_en[2] is 1. Bits 0, 5 and 6 of `lsr_in` do not set it.
- R4: While cfg_en[0] is 1, two causes can be set at the next edge. The data-available cause (bit 1) is set when rx_count is non-zero and at least rx_trig. The timeout cause (bit 2) is set by a one-cycle pulse on `rx_timeout_ev`.
- R5: The transmit-space cause (bit 3) is set at the edge after `tx_space_ok` is high while cfg_en[1] is 1.
- R6: The modem inputs use the order CTS=0, DSR=1, RI=2, DCD=3.
  - Any edge on modem_in[i] sets delta bit 8+i at the next clock edge.
  - The levels appear at bits [15:12] one edge late.
  - An edge also sets the modem cause (bit 4) when cfg_en[3] is 1.
  - Delta bits are kept whether or not cfg_en[3] is set.
- R7: A low-byte write (`host_wr` high with `host_wdata`) clears, at the next edge, each cause bit i in [4:0] whose mask bit is 1. Writing bit 4 also clears all delta bits. Cause bits whose mask bit is 0, and the count bits [7:6], are unaffected.
- R8: When a cause's set condition is present in the same cycle as its acknowledge, the bit stays set. A condition that is still present after acknowledge therefore keeps the bit set.
- R9: A cause whose enable is 0 never becomes pending, whatever its inputs do.
- R10: `irq` is 1 exactly when a pending cause has its enable set. The enable mapping is: cause 0 uses cfg_en[2], causes 1 and 2 use cfg_en[0], cause 3 uses cfg_en[1], and cause 4 uses cfg_en[3]. Clearing an enable drops `irq` at once, but the pending bit is kept.
- R11: Several cause bits can be pending together. Acknowledging one of them leaves the others pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 4 | Cause enables: [0] receive, [1] transmit space, [2] line status, [3] modem |
| lsr_in | input | 8 | Line status byte from the receiver/transmitter |
| rx_count | input | 10 | Receive FIFO fill count |
| rx_trig | input | 10 | Receive fill level that raises data available |
| rx_timeout_ev | input | 1 | Character timeout event pulse |
| tx_space_ok | input | 1 | Transmit FIFO has space (level) |
| modem_in | input | 4 | Modem levels: CTS, DSR, RI, DCD at bits 0..3 |
| host_wr | input | 1 | Host byte write to the low byte of the status word |
| host_wdata | input | 8 | Acknowledge mask written by the host |
| status_word | output | 32 | Packed causes, modem byte, line byte and fill count |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `modem_in` is already synchronous to `clk`.
- `rx_timeout_ev` lasts one cycle.
- The line and fill-count inputs are plain levels that the block never stores.

The bench changes every input only on the falling clock edge and returns each one to an idle value before the next scenario. Because of this, each rise of a cause bit can be traced to the inputs of the cycle before it. The collision scenario drives an acknowledge and a fresh condition in the same cycle on purpose, to show that the set wins.

// File: rtl/uis_pkg.sv
package uis_pkg;
    localparam int NCAUSE = 5;
    localparam int CNT_W  = 10;
    localparam int MDM_W  = 4;
    localparam int LSR_W  = 8;
    localparam int EN_W   = 4;

    localparam int C_LINE = 0;
    localparam int C_RXDA = 1;
    localparam int C_TMO  = 2;
    localparam int C_TXSP = 3;
    localparam int C_MDM  = 4;

    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    // overrun, parity, framing, break, rx fifo error
    localparam logic [LSR_W-1:0] LSR_ERR_MASK = 8'h9E;

    typedef struct packed {
        logic [MDM_W-1:0] level;
        logic [MDM_W-1:0] delta;
    } mdm_t;

    function automatic logic [NCAUSE-1:0] cause_enable_map(logic [EN_W-1:0] en);
        logic [NCAUSE-1:0] m;
        m[C_LINE] = en[EN_LINE];
        m[C_RXDA] = en[EN_RX];
        m[C_TMO]  = en[EN_RX];
        m[C_TXSP] = en[EN_TX];
        m[C_MDM]  = en[EN_MDM];
        return m;
    endfunction

    function automatic logic [31:0] pack_status(logic [NCAUSE-1:0] pend, mdm_t m,
                                                logic [LSR_W-1:0] lsr,
                                                logic [CNT_W-1:0] cnt);
        return {cnt[7:0], lsr, m, cnt[9:8], 1'b0, pend};
    endfunction
endpackage

// File: rtl/uis_modem_track.sv
module uis_modem_track #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_in,
    input  logic         clr,
    output logic [W-1:0] level_q,
    output logic [W-1:0] delta_q,
    output logic [W-1:0] edge_o
);
    logic primed;

    assign edge_o = primed ? (lvl_in ^ level_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            level_q <= '0;
            delta_q <= '0;
        end else begin
            primed  <= 1'b1;
            level_q <= lvl_in;
            delta_q <= (delta_q & ~{W{clr}}) | edge_o;
        end
    end
endmodule

// File: rtl/uis_cause_bank.sv
module uis_cause_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (ack_i[i])
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uis_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int MW = MDM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [EN_W-1:0]     cfg_en,
    input  logic [LSR_W-1:0]    lsr_in,
    input  logic [CW-1:0]       rx_count,
    input  logic [CW-1:0]       rx_trig,
    input  logic                rx_timeout_ev,
    input  logic                tx_space_ok,
    input  logic [MW-1:0]       modem_in,
    input  logic                host_wr,
    input  logic [7:0]          host_wdata,
    output logic [31:0]         status_word,
    output logic                irq
);
    logic [NCAUSE-1:0] en_map, cond, set_vec, ack_vec, pend;
    logic [MW-1:0]     lvl_q, dlt_q, mdm_edge;
    mdm_t              msr;

    assign en_map  = cause_enable_map(cfg_en);
    assign ack_vec = host_wr ? host_wdata[NCAUSE-1:0] : '0;

    always_comb begin
        cond         = '0;
        cond[C_LINE] = |(lsr_in & LSR_ERR_MASK);
        cond[C_RXDA] = (rx_count != '0) && (rx_count >= rx_trig);
        cond[C_TMO]  = rx_timeout_ev;
        cond[C_TXSP] = tx_space_ok;
        cond[C_MDM]  = |mdm_edge;
    end

    assign set_vec = cond & en_map;

    uis_modem_track #(.W(MW)) i_modem (
        .clk     (clk),
        .rst     (rst),
        .lvl_in  (modem_in),
        .clr     (ack_vec[C_MDM]),
        .level_q (lvl_q),
        .delta_q (dlt_q),
        .edge_o  (mdm_edge)
    );

    uis_cause_bank #(.N(NCAUSE)) i_causes (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .ack_i  (ack_vec),
        .pend_o (pend)
    );

    assign msr.level   = lvl_q;
    assign msr.delta   = dlt_q;
    assign status_word = pack_status(pend, msr, lsr_in, rx_count);
    assign irq         = |(pend & en_map);
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cfg_en,
    input logic [7:0]  lsr_in,
    input logic [9:0]  rx_count,
    input logic        tx_space_ok,
    input logic [3:0]  modem_in,
    input logic        host_wr,
    input logic [7:0]  host_wdata,
    input logic [31:0] status_word,
    input logic        irq
);
    // R2
    count_split_chk: assert property (@(posedge clk) disable iff (rst)
        ({status_word[7:6], status_word[31:24]} == rx_count) && !status_word[5]);

    // R3
    line_cause_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[0]) |-> $past(cfg_en[2] && (|(lsr_in & 8'h9E))));

    // R9
    tx_cause_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[3]) |-> $past(cfg_en[1] && tx_space_ok));

    // R6
    modem_cause_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[4]) |-> $past(cfg_en[3] && (modem_in != status_word[15:12])));

    // R7
    tx_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_wdata[3] && !(cfg_en[1] && tx_space_ok)) |=> !status_word[3]);

    // R10
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|status_word[4:0]));
endmodule

bind uart_irq_status uart_irq_status_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .lsr_in      (lsr_in),
    .rx_count    (rx_count),
    .tx_space_ok (tx_space_ok),
    .modem_in    (modem_in),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cfg_en;
    logic [7:0]  lsr_in;
    logic [9:0]  rx_count, rx_trig;
    logic        rx_timeout_ev, tx_space_ok;
    logic [3:0]  modem_in;
    logic        host_wr;
    logic [7:0]  host_wdata;
    logic [31:0] status_word;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_status i_uart_irq_status (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .lsr_in(lsr_in),
        .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout_ev(rx_timeout_ev),
        .tx_space_ok(tx_space_ok), .modem_in(modem_in), .host_wr(host_wr),
        .host_wdata(host_wdata), .status_word(status_word), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ack(input logic [7:0] m);
        host_wr = 1'b1; host_wdata = m;
        step();
        host_wr = 1'b0; host_wdata = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1 causes", {27'd0, status_word[4:0]}, 32'd0);
        chk("R1 modem byte", {24'd0, status_word[15:8]}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_layout();
        rx_count = 10'h2A5; lsr_in = 8'h21;
        #1;
        chk("R2 layout", status_word, 32'hA521_0080);
        ack(8'hC0);
        chk("R7 count bits untouched", {30'd0, status_word[7:6]}, 32'd2);
        rx_count = 10'd0; lsr_in = 8'h00;
    endtask

    task automatic t_disabled();
        cfg_en = 4'b0000;
        lsr_in = 8'h9E; tx_space_ok = 1'b1; rx_timeout_ev = 1'b1;
        rx_trig = 10'd1; rx_count = 10'd5; modem_in = 4'b0100;
        step();
        rx_timeout_ev = 1'b0;
        step();
        chk("R9 no cause when disabled", {27'd0, status_word[4:0]}, 32'd0);
        chk("R9 irq low when disabled", {31'd0, irq}, 32'd0);
        chk("R6 delta kept without enable", {24'd0, status_word[15:8]}, 32'h44);
        lsr_in = 8'h00; tx_space_ok = 1'b0; rx_count = 10'd0;
        modem_in = 4'b0000;
        step();
        chk("R6 falling edge delta", {24'd0, status_word[15:8]}, 32'h04);
        ack(8'h10);
        chk("R7 modem ack clears deltas", {24'd0, status_word[15:8]}, 32'h00);
    endtask

    task automatic t_line();
        cfg_en = 4'b0100;
        lsr_in = 8'h61;
        step();
        chk("R3 non-error lsr bits ignored", {31'd0, status_word[0]}, 32'd0);
        lsr_in = 8'h04;
        step();
        lsr_in = 8'h00;
        chk("R3 parity sets line cause", {27'd0, status_word[4:0]}, 32'h01);
        chk("R10 irq with line cause", {31'd0, irq}, 32'd1);
        ack(8'h01);
        chk("R7 line ack", {27'd0, status_word[4:0]}, 32'h00);
        chk("R10 irq after ack", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_rx();
        cfg_en = 4'b0001; rx_trig = 10'd8;
        rx_count = 10'd7;
        step();
        chk("R4 below trigger", {31'd0, status_word[1]}, 32'd0);
        rx_count = 10'd8;
        step();
        chk("R4 data available at trigger", {27'd0, status_word[4:0]}, 32'h02);
        rx_count = 10'd7;
        ack(8'h02);
        step();
        chk("R4 cleared below trigger", {31'd0, status_word[1]}, 32'd0);
        rx_timeout_ev = 1'b1;
        step();
        rx_timeout_ev = 1'b0;
        step();
        chk("R4 timeout pulse latched", {27'd0, status_word[4:0]}, 32'h04);
        ack(8'h04);
        chk("R7 timeout ack", {27'd0, status_word[4:0]}, 32'h00);
        rx_count = 10'd0;
    endtask

    task automatic t_tx();
        cfg_en = 4'b0010;
        tx_space_ok = 1'b1;
        step();
        chk("R5 tx space cause", {27'd0, status_word[4:0]}, 32'h08);
        ack(8'h08);
        chk("R8 condition present keeps bit", {31'd0, status_word[3]}, 32'd1);
        cfg_en = 4'b0000;
        #1;
        chk("R10 irq drops with enable", {31'd0, irq}, 32'd0);
        chk("R10 pending kept", {31'd0, status_word[3]}, 32'd1);
        tx_space_ok = 1'b0;
        ack(8'h08);
        chk("R7 tx ack", {31'd0, status_word[3]}, 32'd0);
    endtask

    task automatic t_modem();
        cfg_en = 4'b1000;
        modem_in = 4'b0001;
        step();
        chk("R6 cts edge", status_word[15:0] & 32'hFF1F, 32'h1110);
        modem_in = 4'b1001;
        step();
        chk("R6 dcd edge", {24'd0, status_word[15:8]}, 32'h99);
        ack(8'h10);
        chk("R7 modem ack", status_word[15:0] & 32'hFF1F, 32'h9000);
        modem_in = 4'b0000;
        step();
        ack(8'h10);
    endtask

    task automatic t_multi();
        cfg_en = 4'b1111;
        lsr_in = 8'h02; tx_space_ok = 1'b1;
        step();
        lsr_in = 8'h00; tx_space_ok = 1'b0;
        chk("R11 two causes pending", {27'd0, status_word[4:0]}, 32'h09);
        ack(8'h01);
        chk("R11 other cause kept", {27'd0, status_word[4:0]}, 32'h08);
        chk("R10 irq still high", {31'd0, irq}, 32'd1);
        ack(8'h08);
        chk("R10 irq low when none pending", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_collide();
        cfg_en = 4'b0100;
        lsr_in = 8'h08;
        step();
        lsr_in = 8'h10; host_wr = 1'b1; host_wdata = 8'h01;
        step();
        host_wr = 1'b0; host_wdata = 8'h00; lsr_in = 8'h00;
        chk("R8 event beats ack", {31'd0, status_word[0]}, 32'd1);
        ack(8'h01);
        chk("R8 later ack clears", {31'd0, status_word[0]}, 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_en = 4'b0; lsr_in = 8'h0; rx_count = 10'd0; rx_trig = 10'd1;
        rx_timeout_ev = 1'b0; tx_space_ok = 1'b0; modem_in = 4'b0;
        host_wr = 1'b0; host_wdata = 8'h0;
        step(); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_layout();
        t_disabled();
        t_line();
        t_rx();
        t_tx();
        t_modem();
        t_multi();
        t_collide();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule